// File: doc/BRIEF.md
# Circular Passing-Window Phase Selector

This block picks one sampling phase out of a ring of sixteen after a tuning sweep. It receives a mask in which each set bit marks a phase that read the tuning pattern correctly. It gathers neighbouring set bits into passing windows. When the window that begins at phase 0 and a different window that reaches phase 15 meet across the wrap point, it joins them into one window. It then returns the phase three quarters of the way into the longest window. The sweep that produces the mask, and the pass/fail judgement behind it, happen elsewhere.

A request is a one-cycle `start_i` pulse carrying the mask. The block then walks the mask one bit per clock. It ends with a one-cycle `done_o` pulse, the chosen phase and an error flag. These outputs stay unchanged until the next `done_o`. While a request is in flight, further `start_i` pulses are ignored.

Top module: `phsel_top`

## Requirements
- R1: After a synchronous active-low reset, `done_o` is 0, `phase_o` is 0 and `err_o` is 0.
- R2: A window is a maximal run of set mask bits (bit k stands for phase k) with consecutive phase numbers. Windows are ordered by ascending starting phase. The longest window is the one used, e.g. mask 16'h03E3 yields phase 7, and mask 16'h8000 yields phase 15.
- R3: When windows tie for the greatest length, the earliest window in that order is used (mask 16'h070E yields 2, mask 16'h5555 yields 0).
- R4: Within the chosen window of length L, the element used is the one at zero-based offset floor(3L/4), minus one when that value is non-zero. For example, L=1 gives offset 0, L=4 gives offset 2, and L=8 gives offset 5.
- R5: When bit 0 and bit 15 are both set and at least one bit is clear, the window containing phase 15 and the window starting at phase 0 form one window. It lists the phase-15 window's phases first and then the phase-0 window's phases. It takes the place of the phase-15 window in the order, and the phase-0 window no longer competes on its own (mask 16'h8001 yields 15, mask 16'hE007 yields 0, mask 16'h8061 yields 5).
- R6: A mask with all sixteen bits set is one window of length 16 with no merge, and yields phase 11 with no error.
- R7: An empty mask sets `err_o` to 1 and `phase_o` to 0. Whenever `err_o` is 1, `phase_o` is 0.
- R8: `done_o` is high for exactly one cycle. It rises on the 17th clock edge after the edge that samples `start_i`. `phase_o` and `err_o` change only on the edge that raises `done_o`.
- R9: A `start_i` pulse that arrives while a request is in flight has no effect. The result and the count of `done_o` pulses are those of the first request alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request pulse; `mask_i` is sampled with it |
| mask_i | input | 16 | Pass mask, bit k set when phase k passed |
| done_o | output | 1 | One-cycle completion pulse |
| phase_o | output | 4 | Selected phase, valid from `done_o` on |
| err_o | output | 1 | Set when no window could be chosen |

## Verification
The hardest case to reach is the merge across the wrap point. Here the merged window must compete last and must lose ties to earlier windows, while the phase-0 window alone must not compete. A mask like 16'h8061 produces this, because the merged window exactly ties an earlier interior window. Masks 16'h80F1 and 16'hC1CF cover the cases where the merged window is shorter and where it wins. Dropping a request that arrives in flight is reached by pulsing `start_i` again in the middle of a scan with a very different mask.

// File: rtl/phsel_pkg.sv
// Shared types for the phase selector.
// Assumes: nothing beyond a single clock domain.
package phsel_pkg;

    // Sequencer states: waiting, walking the mask, presenting the result.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } phsel_state_e;

endpackage

// File: rtl/phsel_ctrl.sv
// Sequencer for one selection request.
// Accepts a start only when idle, then steps a bit index across all
// NUM_PH phases (one per clock), then spends one cycle in the result state.
// Assumes: NUM_PH is a power of two and at least 2.
module phsel_ctrl
    import phsel_pkg::*;
#(
    parameter int NUM_PH = 16,
    localparam int PW = $clog2(NUM_PH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic [PW-1:0] idx_o,
    output logic          capture_o,
    output logic          step_o,
    output logic          finish_o,
    output logic          busy_o
);

    localparam logic [PW-1:0] LAST_IDX = PW'(NUM_PH - 1);

    phsel_state_e state_q;
    logic [PW-1:0] idx_q;

    // Advance through idle, scan and result states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_SCAN;
                        idx_q   <= '0;
                    end
                end
                ST_SCAN: begin
                    if (idx_q == LAST_IDX) begin
                        state_q <= ST_DONE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode the per-cycle strobes from the state.
    always_comb begin
        capture_o = (state_q == ST_IDLE) && start_i;
        step_o    = (state_q == ST_SCAN);
        finish_o  = (state_q == ST_DONE);
        busy_o    = (state_q != ST_IDLE);
        idx_o     = idx_q;
    end

endmodule

// File: rtl/phsel_scan.sv
// Window tracker. It holds the captured mask and walks it one bit per step.
// It measures each run of set bits as that run closes and keeps the start
// and length of the longest run; on equal length the earlier run stays.
// With the wrap merge active, the run starting at phase 0 is only
// remembered, and its length is added to the final run that reaches the top
// phase. A wrap total of NUM_PH or more raises a guard flag.
// Assumes: idx_i counts 0..NUM_PH-1 on consecutive step cycles.
module phsel_scan #(
    parameter int NUM_PH = 16,
    localparam int PW = $clog2(NUM_PH),
    localparam int LW = $clog2(NUM_PH + 1),
    localparam int CW = LW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              step_i,
    input  logic [NUM_PH-1:0] mask_i,
    input  logic [PW-1:0]     idx_i,
    output logic [PW-1:0]     best_start_o,
    output logic [CW-1:0]     best_len_o,
    output logic              wrap_err_o
);

    localparam logic [PW-1:0] LAST_IDX = PW'(NUM_PH - 1);
    localparam logic [CW-1:0] FULL_LEN = CW'(NUM_PH);

    logic [NUM_PH-1:0] mask_q;
    logic              merge_q;
    logic [LW-1:0]     run_len_q;
    logic [PW-1:0]     run_start_q;
    logic [LW-1:0]     head_len_q;
    logic [PW-1:0]     best_start_q;
    logic [CW-1:0]     best_len_q;
    logic              wrap_err_q;

    logic          at_last;
    logic [PW-1:0] idx_next;
    logic          bit_now;
    logic          bit_next;
    logic [LW-1:0] seg_len;
    logic [PW-1:0] seg_start;
    logic          seg_end;
    logic          is_head;
    logic [CW-1:0] cand_len;

    // Extend or open the run at the current bit and decide whether it closes here.
    always_comb begin
        at_last   = (idx_i == LAST_IDX);
        idx_next  = idx_i + 1'b1;
        bit_now   = mask_q[idx_i];
        bit_next  = at_last ? 1'b0 : mask_q[idx_next];
        seg_len   = (run_len_q == '0) ? LW'(1) : run_len_q + 1'b1;
        seg_start = (run_len_q == '0) ? idx_i : run_start_q;
        seg_end   = bit_now && !bit_next;
        is_head   = merge_q && (seg_start == '0);
        cand_len  = {1'b0, seg_len}
                  + ((merge_q && at_last) ? {1'b0, head_len_q} : '0);
    end

    // Capture the request, then track the runs and the best window per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q       <= '0;
            merge_q      <= 1'b0;
            run_len_q    <= '0;
            run_start_q  <= '0;
            head_len_q   <= '0;
            best_start_q <= '0;
            best_len_q   <= '0;
            wrap_err_q   <= 1'b0;
        end else if (capture_i) begin
            mask_q       <= mask_i;
            merge_q      <= mask_i[0] && mask_i[NUM_PH-1] && !(&mask_i);
            run_len_q    <= '0;
            run_start_q  <= '0;
            head_len_q   <= '0;
            best_start_q <= '0;
            best_len_q   <= '0;
            wrap_err_q   <= 1'b0;
        end else if (step_i && bit_now) begin
            if (seg_end) begin
                run_len_q <= '0;
                if (is_head) begin
                    head_len_q <= seg_len;
                end else begin
                    if (cand_len > best_len_q) begin
                        best_len_q   <= cand_len;
                        best_start_q <= seg_start;
                    end
                    if (merge_q && at_last && (cand_len >= FULL_LEN)) begin
                        wrap_err_q <= 1'b1;
                    end
                end
            end else begin
                run_len_q   <= seg_len;
                run_start_q <= seg_start;
            end
        end
    end

    // Present the tracked best window.
    always_comb begin
        best_start_o = best_start_q;
        best_len_o   = best_len_q;
        wrap_err_o   = wrap_err_q;
    end

endmodule

// File: rtl/phsel_pick.sv
// Three-quarter point of a window. The offset is floor(3*len/4), less one
// when non-zero, added to the window start modulo the ring size.
// Assumes: NUM_PH is a power of two, so truncation gives the wrap.
module phsel_pick #(
    parameter int NUM_PH = 16,
    localparam int PW = $clog2(NUM_PH),
    localparam int LW = $clog2(NUM_PH + 1),
    localparam int CW = LW + 1
) (
    input  logic [PW-1:0] start_i,
    input  logic [CW-1:0] len_i,
    output logic [PW-1:0] phase_o
);

    logic [CW+1:0] triple;
    logic [CW+1:0] quarter;
    logic [CW+1:0] offset;
    logic [PW-1:0] offset_lo;

    // Scale the length, derive the offset and wrap it onto the ring.
    always_comb begin
        triple    = {2'b00, len_i} + {1'b0, len_i, 1'b0};
        quarter   = triple >> 2;
        offset    = (quarter != '0) ? quarter - 1'b1 : '0;
        offset_lo = offset[PW-1:0];
        phase_o   = start_i + offset_lo;
    end

endmodule

// File: rtl/phsel_top.sv
// Circular passing-window phase selector. It takes a pass mask with a start
// pulse, finds the longest window of passing phases on the ring, and returns
// its three-quarter point with a one-cycle done pulse.
// Assumes: start_i is only honoured while idle; the outputs hold between results.
module phsel_top #(
    parameter int NUM_PH = 16,
    localparam int PW = $clog2(NUM_PH),
    localparam int LW = $clog2(NUM_PH + 1),
    localparam int CW = LW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NUM_PH-1:0] mask_i,
    output logic              done_o,
    output logic [PW-1:0]     phase_o,
    output logic              err_o
);

    logic [PW-1:0] idx;
    logic          capture;
    logic          step;
    logic          finish;
    logic          busy;
    logic [PW-1:0] best_start;
    logic [CW-1:0] best_len;
    logic          wrap_err;
    logic [PW-1:0] pick_phase;
    logic          fail_now;

    phsel_ctrl #(.NUM_PH(NUM_PH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .idx_o     (idx),
        .capture_o (capture),
        .step_o    (step),
        .finish_o  (finish),
        .busy_o    (busy)
    );

    phsel_scan #(.NUM_PH(NUM_PH)) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture_i    (capture),
        .step_i       (step),
        .mask_i       (mask_i),
        .idx_i        (idx),
        .best_start_o (best_start),
        .best_len_o   (best_len),
        .wrap_err_o   (wrap_err)
    );

    phsel_pick #(.NUM_PH(NUM_PH)) u_pick (
        .start_i (best_start),
        .len_i   (best_len),
        .phase_o (pick_phase)
    );

    // Failure when no window was found or the wrap guard tripped.
    always_comb begin
        fail_now = (best_len == '0) || wrap_err;
    end

    // Register the result and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o  <= 1'b0;
            phase_o <= '0;
            err_o   <= 1'b0;
        end else begin
            done_o <= finish;
            if (finish) begin
                err_o   <= fail_now;
                phase_o <= fail_now ? '0 : pick_phase;
            end
        end
    end

endmodule

// File: rtl/phsel_chk.sv
// Property checker for the phase selector, attached to phsel_top by bind.
// Watches the result handshake and the internal busy strobe.
module phsel_chk #(
    parameter int NUM_PH = 16,
    localparam int PW = $clog2(NUM_PH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy,
    input logic          done_o,
    input logic [PW-1:0] phase_o,
    input logic          err_o
);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    err_zero_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (phase_o == '0));

    // R8
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(phase_o) && $stable(err_o)));

    // R8
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> busy);

    // R8
    done_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy));

endmodule

bind phsel_top phsel_chk #(.NUM_PH(NUM_PH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy    (busy),
    .done_o  (done_o),
    .phase_o (phase_o),
    .err_o   (err_o)
);

// File: tb/phsel_top_test.sv
// Self-checking bench for phsel_top: a table of masks with hand-worked
// results, then directed checks of reset, timing and dropped starts.
module phsel_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 16;
    localparam int NV         = 18;
    // Edges counted from the start-sampling edge itself up to the done edge.
    localparam int EXP_LAT    = NP + 2;

    // Entry: {mask[15:0], err, phase[3:0]}
    localparam logic [20:0] VEC [NV] = '{
        {16'hFFFF, 1'b0, 4'd11},
        {16'h0000, 1'b1, 4'd0},
        {16'h0020, 1'b0, 4'd5},
        {16'h0030, 1'b0, 4'd4},
        {16'h0F00, 1'b0, 4'd10},
        {16'h03FC, 1'b0, 4'd7},
        {16'h03E3, 1'b0, 4'd7},
        {16'h070E, 1'b0, 4'd2},
        {16'hE007, 1'b0, 4'd0},
        {16'hC1CF, 1'b0, 4'd1},
        {16'h80F1, 1'b0, 4'd6},
        {16'h8001, 1'b0, 4'd15},
        {16'h8000, 1'b0, 4'd15},
        {16'h0001, 1'b0, 4'd0},
        {16'h5555, 1'b0, 4'd0},
        {16'hAAAA, 1'b0, 4'd1},
        {16'h8061, 1'b0, 4'd5},
        {16'hFF7F, 1'b0, 4'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [NP-1:0] mask_i = '0;
    logic          done_o;
    logic [3:0]    phase_o;
    logic          err_o;

    int n_checks = 0;
    int n_fails  = 0;

    phsel_top #(.NUM_PH(NP)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .mask_i  (mask_i),
        .done_o  (done_o),
        .phase_o (phase_o),
        .err_o   (err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string tag_of(input int i);
        case (i)
            0:                 return "R6";
            1:                 return "R7";
            2, 3, 4, 5:        return "R4";
            6, 12, 13:         return "R2";
            7, 14, 15, 16:     return "R3";
            default:           return "R5";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    // Issue one request and check latency, result and pulse width.
    task automatic run_case(input logic [NP-1:0] m, input logic e_err,
                            input logic [3:0] e_ph, input string req);
        int lat;
        mask_i  = m;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        mask_i  = '0;
        lat = 1;
        while (!done_o && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check("R8", "latency", lat, EXP_LAT);
        check(req, "err", int'(err_o), int'(e_err));
        check(req, "phase", int'(phase_o), int'(e_ph));
        @(negedge clk);
        check("R8", "done width", int'(done_o), 0);
        check("R8", "phase held", int'(phase_o), int'(e_ph));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "done", int'(done_o), 0);
        check("R1", "phase", int'(phase_o), 0);
        check("R1", "err", int'(err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_case(VEC[i][20:5], VEC[i][4], VEC[i][3:0], tag_of(i));
            @(negedge clk);
        end

        // R9: a second start during the scan is dropped
        begin
            int dones;
            mask_i  = 16'h0020;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (3) @(negedge clk);
            mask_i  = 16'hFFFF;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            mask_i  = '0;
            dones = 0;
            for (int c = 0; c < 3 * NP; c++) begin
                if (done_o) begin
                    dones++;
                    check("R9", "phase", int'(phase_o), 5);
                    check("R9", "err", int'(err_o), 0);
                end
                @(negedge clk);
            end
            check("R9", "done count", dones, 1);
        end

        // R7: an error result followed by a good one clears the flag
        run_case(16'h0000, 1'b1, 4'd0, "R7");
        run_case(16'h0010, 1'b0, 4'd4, "R7");

        // R1: reset in mid-scan returns outputs to the reset values
        mask_i  = 16'hFFFF;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", "phase after reset", int'(phase_o), 0);
        check("R1", "done after reset", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_case(16'hE007, 1'b0, 4'd0, "R5");

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule